// File: doc/BRIEF.md
# Frame Luminance Histogram with Host Lockout

This block counts how many pixels of each video frame fall into each of a fixed set of brightness bins. Pixels arrive as a stream qualified by a valid strobe. A separate end-of-frame strobe marks the cycle that closes a frame. While a frame streams in, the counts build up in a working bank. When the frame closes, the block copies the finished counts into a result bank, and the host reads the result bank one bin at a time through an index port.

A two-bit control/status register lets the host freeze the result bank. While the lock bit is set, frame ends no longer overwrite the published counts, so the host can read every bin from one frame. Counting in the working bank does not stop during a lock, and the working bank still restarts at zero at every frame boundary. A status bit tells the host that fresh results have been published. Writing a 1 to the lock bit clears the status bit, which gives a simple handshake: the host waits for status, locks the bank, reads it, then unlocks.

Top module: `frame_histogram`

## Requirements
- R1: After reset the control register reads 0 (lock and status both clear) and every published bin reads 0.
- R2: A pixel counts only in a cycle where pix_valid is 1. It adds one to the bin given by its upper BIN_W bits (bits 11:4 at the defaults, 256 bins). A pixel presented with pix_valid at 0 changes no count.
- R3: With the lock clear, a pix_eof cycle publishes that frame's counts. The published counts include a valid pixel presented in the same cycle as pix_eof.
- R4: Control register bit 1 (status) goes to 1 on the clock edge that publishes a new histogram and goes to 1 at no other time.
- R5: With the lock set, a frame end leaves every published bin unchanged.
- R6: Counting continues while the lock is set. The working bank restarts from zero after every pix_eof, whether or not that frame was published. When the lock is cleared in the middle of a frame, the next frame end publishes all pixels since the previous pix_eof, including those that arrived while the lock was set.
- R7: A control write with data 1 clears status. A control write with data 0 leaves status unchanged.
- R8: Control register bit 0 reads back the lock value of the last control write.
- R9: Each bin count saturates at its all-ones value (2^CNT_W-1) and does not wrap.
- R10: When a control write of 1 falls in the same cycle as pix_eof, the lock takes effect at once. That frame is not published and status ends at 0.
- R11: rd_count shows the published count of the bin selected by rd_idx one clock edge after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_data | input | PIX_W | Pixel luminance |
| pix_eof | input | 1 | Last cycle of the frame |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 1 | Lock value written |
| ctrl_rdata | output | 2 | {status, lock} |
| rd_idx | input | BIN_W | Bin index to read |
| rd_count | output | CNT_W | Published count of the selected bin |

## Verification
The hardest state to reach from the ports is a collision: a lock write landing in exactly the same cycle as a frame end, after status has already been set. The bench reaches it by driving both strobes together in one cycle and then reading the published bank back to show that no refresh happened. Saturation is also hard to reach with 24-bit counters, so the bench builds the block with a 10-bit count width and streams more than 1023 pixels into a single bin. Accumulation during a lock is shown by unlocking in the middle of a frame and checking that the pixels streamed while locked appear in the next published result.

// File: rtl/frame_histogram.sv
module frame_histogram #(
  parameter int PIX_W = 12,
  parameter int BIN_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_eof,
  input  logic             ctrl_wr,
  input  logic             ctrl_wdata,
  output logic [1:0]       ctrl_rdata,
  input  logic [BIN_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_count
);
  localparam int NBINS = 1 << BIN_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             lock_q, status_q;
  logic             lock_nxt, publish;
  logic [BIN_W-1:0] bin;
  logic [NBINS*CNT_W-1:0] pub_flat;
  logic             unused_low;

  assign bin        = pix_data[PIX_W-1 -: BIN_W];
  assign unused_low = ^pix_data[PIX_W-BIN_W-1:0];
  assign lock_nxt   = ctrl_wr ? ctrl_wdata : lock_q;
  assign publish    = pix_eof && !lock_nxt;
  assign ctrl_rdata = {status_q, lock_q};

  for (genvar i = 0; i < NBINS; i++) begin : g_bin
    logic [CNT_W-1:0] work_q, pub_q, inc;
    logic             hit;
    assign hit = pix_valid && (bin == BIN_W'(i));
    assign inc = (hit && work_q != CMAX) ? work_q + 1'b1 : work_q;
    assign pub_flat[i*CNT_W +: CNT_W] = pub_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        work_q <= '0;
        pub_q  <= '0;
      end else begin
        work_q <= pix_eof ? '0 : inc;
        if (publish) pub_q <= inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      status_q <= 1'b0;
      rd_count <= '0;
    end else begin
      lock_q   <= lock_nxt;
      if (ctrl_wr && ctrl_wdata) status_q <= 1'b0;
      else if (publish)          status_q <= 1'b1;
      rd_count <= pub_flat[rd_idx*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/frame_histogram_checker.sv
module frame_histogram_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_eof,
  input logic       ctrl_wr,
  input logic       ctrl_wdata,
  input logic [1:0] ctrl_rdata
);
  assert_status_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_eof && !ctrl_wr && !ctrl_rdata[0]) |=> ctrl_rdata[1]);

  assert_status_only_at_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rdata[1]) |-> $past(pix_eof));

  assert_lock_clears_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata) |=> !ctrl_rdata[1]);

  assert_lock_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_rdata[0] == $past(ctrl_wdata)));

  assert_collision_no_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_eof && ctrl_wr && ctrl_wdata) |=> (ctrl_rdata == 2'b01));

  assert_no_publish_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[0] && !ctrl_wr && !ctrl_rdata[1]) |=> !ctrl_rdata[1]);
endmodule

bind frame_histogram frame_histogram_checker chk_i (
  .clk(clk), .rst_n(rst_n), .pix_eof(pix_eof),
  .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata)
);

// File: tb/frame_histogram_tb_top.sv
module frame_histogram_tb_top;
  localparam int CW = 10;
  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pix_eof = 0, ctrl_wr = 0, ctrl_wdata = 0;
  logic [11:0] pix_data = '0;
  logic [7:0] rd_idx = '0;
  logic [1:0] ctrl_rdata;
  logic [CW-1:0] rd_count;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  frame_histogram #(.PIX_W(12), .BIN_W(8), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_eof(pix_eof), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .rd_idx(rd_idx), .rd_count(rd_count));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic px(input logic v, input logic [11:0] d, input logic e);
    @(negedge clk);
    pix_valid = v; pix_data = d; pix_eof = e;
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 0; pix_eof = 0; ctrl_wr = 0;
  endtask

  task automatic wr(input logic v);
    @(negedge clk);
    ctrl_wr = 1; ctrl_wdata = v;
    idle();
  endtask

  // R11: value sampled one edge after rd_idx is applied
  task automatic rd_chk(input string req, input int idx, input int exp);
    @(negedge clk);
    rd_idx = idx[7:0];
    @(negedge clk);
    chk(req, int'(rd_count), exp);
  endtask

  task automatic t_reset();
    chk("R1 ctrl", int'(ctrl_rdata), 0);
    rd_chk("R1 bin0", 0, 0);
    rd_chk("R1 bin255", 255, 0);
  endtask

  task automatic t_basic();
    px(1, 12'h000, 0); px(1, 12'h00F, 0); px(1, 12'h010, 0);
    px(0, 12'h020, 0);
    for (int i = 0; i < 3; i++) px(1, 12'hFFF, 0);
    px(1, 12'h7F0, 1);
    idle();
    chk("R4 status", int'(ctrl_rdata), 2);
    rd_chk("R2 bin0", 0, 2);
    rd_chk("R2 bin1", 1, 1);
    rd_chk("R2 invalid bin2", 2, 0);
    rd_chk("R2 bin255", 255, 3);
    rd_chk("R3 eof pixel bin127", 127, 1);
    rd_chk("R11 bin255 again", 255, 3);
  endtask

  task automatic t_lock();
    wr(0);
    chk("R7 write0 keeps status", int'(ctrl_rdata), 2);
    wr(1);
    chk("R7 R8 lock clears status", int'(ctrl_rdata), 1);
    for (int i = 0; i < 4; i++) px(1, 12'h050, 0);
    px(0, 0, 1);
    idle();
    chk("R5 no status while locked", int'(ctrl_rdata), 1);
    rd_chk("R5 bin0 frozen", 0, 2);
    rd_chk("R5 bin5 not published", 5, 0);
    // locked frame with pixels, then unlock mid-frame
    px(1, 12'h090, 0); px(1, 12'h095, 0);
    idle();
    wr(0);
    chk("R8 lock readback 0", int'(ctrl_rdata), 0);
    px(1, 12'h0A0, 1);
    idle();
    chk("R4 status after unlock frame", int'(ctrl_rdata), 2);
    rd_chk("R6 locked pixels counted", 9, 2);
    rd_chk("R6 bin10", 10, 1);
    rd_chk("R6 working cleared bin5", 5, 0);
    rd_chk("R6 old bin0 replaced", 0, 0);
  endtask

  task automatic t_collide();
    px(1, 12'h030, 0);
    @(negedge clk);
    pix_valid = 0; pix_eof = 1; ctrl_wr = 1; ctrl_wdata = 1;
    idle();
    chk("R10 collision ctrl", int'(ctrl_rdata), 1);
    rd_chk("R10 bin3 not published", 3, 0);
    rd_chk("R10 bin9 kept", 9, 2);
  endtask

  task automatic t_sat();
    wr(0);
    for (int i = 0; i < 1030; i++) px(1, 12'hC85, 0);
    px(1, 12'hC80, 1);
    idle();
    rd_chk("R9 saturated", 200, 1023);
    chk("R4 status after sat frame", int'(ctrl_rdata), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lock();
    t_collide();
    t_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule